// File: doc/BRIEF.md
# Accelerator Control Register File

This block is the processor-facing control slave for a single compute core. A processor reaches it over AXI4-Lite and uses it to launch the core, to watch the core's handshake, to hand over two address arguments and an instruction word, and to collect a status word and a 64-bit result. The block drives the core's start line. It records the core's done, ready and output-valid pulses in sticky flags, so that software does not miss a one-cycle event.

Each register bit has its own access rule. Some bits are plain read/write. The done flag and the two output-valid flags clear when they are read. The start bit clears itself when the core accepts a launch. The interrupt status bits flip when a 1 is written to them. One level-sensitive interrupt line combines a global enable, the per-channel enables and the status bits. An auto-restart mode keeps the core running back to back with no software action between runs.

Register offsets are byte addresses. A register is selected by address bits `[ADDR_W-1:2]`, so the two lowest address bits are ignored. Byte strobe 0 qualifies writes to the control, enable and status words. Every byte strobe qualifies its own byte of the argument words.

Top module: `acc_ctrl_regs`

## Requirements
- R1: Out of reset, every register reads zero, `core_start_o` and `irq_o` are low, `bvalid_o` and `rvalid_o` are low, and the argument outputs are zero.
- R2: Each accepted write returns exactly one `bvalid_o` with `bresp_o` = 2'b00, held until `bready_i`. Each accepted read returns exactly one `rvalid_o` with `rresp_o` = 2'b00, held with stable data until `rready_i`. While a response is pending, the ready signals for that channel stay low.
- R3: Writing 1 to bit 0 at offset 0x00 raises `core_start_o` after the write. Writing 0 to bit 0 leaves it unchanged. With auto-restart clear, start drops after a cycle in which `core_ready_i` is high.
- R4: Bit 7 at offset 0x00 is a read/write auto-restart flag. While it is set, a `core_ready_i` pulse does not drop start, and a `core_done_i` pulse raises start.
- R5: Bit 1 at offset 0x00 is set by a `core_done_i` pulse and cleared by a read of 0x00. The read returns the value held before the clear. A done pulse in the same cycle as the clearing read leaves the bit set. Bit 2 mirrors `core_idle_i` and bit 3 mirrors `core_ready_i`.
- R6: Bit 0 at offset 0x04 is the global interrupt enable. Bits 1:0 at offset 0x08 are the channel enables. Both are read/write, and all other bits in these words read zero.
- R7: At offset 0x0C, bit 0 is set by `core_done_i` and bit 1 by `core_ready_i`. Writing 1 to a bit flips it. If an event falls in the same cycle as a flip, the bit ends set.
- R8: `irq_o` is high exactly when the global enable is set and, for at least one channel, both the enable bit and the status bit are set.
- R9: Offsets 0x10, 0x18 and 0x34 are read/write 32-bit words driven onto `arg_a_o`, `arg_b_o` and `instr_o`. Each write strobe bit qualifies one byte.
- R10: Offset 0x20 returns `stat_i` as captured at the last `stat_vld_i` pulse. Bit 0 at offset 0x24 is a valid flag that sets on that pulse and clears when read.
- R11: Offsets 0x28 and 0x2C return bits 31:0 and bits 63:32 of `res_i` as captured at the last `res_vld_i` pulse. Bit 0 at offset 0x30 is a valid flag that sets on that pulse and clears when read.
- R12: Reads of offsets 0x14, 0x1C, 0x38, 0x3C and any other unmapped word return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awaddr_i | input | ADDR_W | Write address |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | DATA_W | Write data |
| wstrb_i | input | DATA_W/8 | Write byte strobes |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bresp_o | output | 2 | Write response, always OKAY |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | ADDR_W | Read address |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rdata_o | output | DATA_W | Read data |
| rresp_o | output | 2 | Read response, always OKAY |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| core_start_o | output | 1 | Start request to the core |
| core_done_i | input | 1 | Core finished a run (pulse) |
| core_idle_i | input | 1 | Core is idle (level) |
| core_ready_i | input | 1 | Core accepted start (pulse) |
| arg_a_o | output | DATA_W | First address argument |
| arg_b_o | output | DATA_W | Second address argument |
| instr_o | output | DATA_W | Instruction word |
| stat_i | input | DATA_W | Status word from the core |
| stat_vld_i | input | 1 | Status word valid (pulse) |
| res_i | input | 2*DATA_W | Result from the core |
| res_vld_i | input | 1 | Result valid (pulse) |
| irq_o | output | 1 | Interrupt request (level) |

## Verification
The risky overlap is a fresh core event landing in the same cycle as the software access that clears it. In one case, the done pulse meets a read of the control word. In the other, it meets a write that flips the matching status bit. The bench drives `core_done_i` high only during the cycle whose closing edge accepts the read or performs the write. It then expects the read to return the old value, a second read to still show the bit, and only a third read to find it cleared. For the status register, a read after the colliding write must show the bit still set.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;

  // word indices (byte offset / 4)
  localparam int unsigned W_CTRL   = 0;
  localparam int unsigned W_GIE    = 1;
  localparam int unsigned W_IER    = 2;
  localparam int unsigned W_ISR    = 3;
  localparam int unsigned W_ARG_A  = 4;
  localparam int unsigned W_ARG_B  = 6;
  localparam int unsigned W_STAT   = 8;
  localparam int unsigned W_STAT_V = 9;
  localparam int unsigned W_RES_LO = 10;
  localparam int unsigned W_RES_HI = 11;
  localparam int unsigned W_RES_V  = 12;
  localparam int unsigned W_INSTR  = 13;

  localparam int unsigned N_ARGS = 3;
  localparam int unsigned ARG_IDX [N_ARGS] = '{W_ARG_A, W_ARG_B, W_INSTR};

  // control word bit positions
  localparam int unsigned B_START = 0;
  localparam int unsigned B_DONE  = 1;
  localparam int unsigned B_IDLE  = 2;
  localparam int unsigned B_READY = 3;
  localparam int unsigned B_AUTO  = 7;

  localparam int unsigned N_IRQ_CH = 2;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/acc_axil_port.sv
module acc_axil_port
  import acc_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W  = ADDR_W - 2,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [STRB_W-1:0] wr_strb_o,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] rd_word_i
);

  logic              aw_held_q, w_held_q, bvalid_q, rvalid_q;
  logic [IDX_W-1:0]  aw_idx_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [STRB_W-1:0] wstrb_q;
  logic              unused_low_bits;

  assign unused_low_bits = ^{awaddr_i[1:0], araddr_i[1:0]};

  // write channel: address and data may arrive in either order
  assign awready_o = !aw_held_q && !bvalid_q;
  assign wready_o  = !w_held_q  && !bvalid_q;
  assign wr_en_o   = aw_held_q && w_held_q;
  assign wr_idx_o  = aw_idx_q;
  assign wr_data_o = wdata_q;
  assign wr_strb_o = wstrb_q;
  assign bvalid_o  = bvalid_q;
  assign bresp_o   = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      aw_idx_q  <= '0;
      wdata_q   <= '0;
      wstrb_q   <= '0;
    end else begin
      if (awvalid_i && awready_o) begin
        aw_held_q <= 1'b1;
        aw_idx_q  <= awaddr_i[ADDR_W-1:2];
      end
      if (wvalid_i && wready_o) begin
        w_held_q <= 1'b1;
        wdata_q  <= wdata_i;
        wstrb_q  <= wstrb_i;
      end
      if (wr_en_o) begin
        aw_held_q <= 1'b0;
        w_held_q  <= 1'b0;
        bvalid_q  <= 1'b1;
      end else if (bvalid_q && bready_i) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  // read channel: data is sampled in the accept cycle, side effects fire there too
  assign arready_o = !rvalid_q;
  assign rd_en_o   = arvalid_i && arready_o;
  assign rd_idx_o  = araddr_i[ADDR_W-1:2];
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign rresp_o   = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_en_o) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_word_i;
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  p_bvalid_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o && !bready_i |=> bvalid_o);
  p_rvalid_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o));
  p_no_write_with_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o |-> !wr_en_o);

endmodule

// File: rtl/acc_run_ctrl.sv
module acc_run_ctrl
  import acc_ctrl_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [STRB_W-1:0] wr_strb_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              core_done_i,
  input  logic              core_idle_i,
  input  logic              core_ready_i,
  output logic              start_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] ctrl_word_o,
  output logic [DATA_W-1:0] gie_word_o,
  output logic [DATA_W-1:0] ier_word_o,
  output logic [DATA_W-1:0] isr_word_o
);

  logic                start_q, start_d, done_q, auto_q, gie_q;
  logic [N_IRQ_CH-1:0] ier_q, isr_q, isr_d, isr_evt, isr_tog;
  logic                wr_ctrl, wr_gie, wr_ier, wr_isr, rd_ctrl;

  assign wr_ctrl = wr_en_i && wr_strb_i[0] && (wr_idx_i == IDX_W'(W_CTRL));
  assign wr_gie  = wr_en_i && wr_strb_i[0] && (wr_idx_i == IDX_W'(W_GIE));
  assign wr_ier  = wr_en_i && wr_strb_i[0] && (wr_idx_i == IDX_W'(W_IER));
  assign wr_isr  = wr_en_i && wr_strb_i[0] && (wr_idx_i == IDX_W'(W_ISR));
  assign rd_ctrl = rd_en_i && (rd_idx_i == IDX_W'(W_CTRL));

  // later assignments take priority: software set wins over handshake clear
  always_comb begin
    start_d = start_q;
    if (core_ready_i && !auto_q) start_d = 1'b0;
    if (core_done_i && auto_q)   start_d = 1'b1;
    if (wr_ctrl && wr_data_i[B_START]) start_d = 1'b1;
  end

  // channel 0 = done, channel 1 = ready; event beats toggle
  assign isr_evt = {core_ready_i, core_done_i};
  assign isr_tog = wr_isr ? wr_data_i[N_IRQ_CH-1:0] : '0;
  assign isr_d   = (isr_q ^ isr_tog) | isr_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      auto_q  <= 1'b0;
      gie_q   <= 1'b0;
      ier_q   <= '0;
      isr_q   <= '0;
    end else begin
      start_q <= start_d;
      done_q  <= (done_q && !rd_ctrl) || core_done_i;
      isr_q   <= isr_d;
      if (wr_ctrl) auto_q <= wr_data_i[B_AUTO];
      if (wr_gie)  gie_q  <= wr_data_i[0];
      if (wr_ier)  ier_q  <= wr_data_i[N_IRQ_CH-1:0];
    end
  end

  assign start_o = start_q;
  assign irq_o   = gie_q && |(ier_q & isr_q);

  always_comb begin
    ctrl_word_o          = '0;
    ctrl_word_o[B_START] = start_q;
    ctrl_word_o[B_DONE]  = done_q;
    ctrl_word_o[B_IDLE]  = core_idle_i;
    ctrl_word_o[B_READY] = core_ready_i;
    ctrl_word_o[B_AUTO]  = auto_q;
  end
  assign gie_word_o = {{(DATA_W-1){1'b0}}, gie_q};
  assign ier_word_o = {{(DATA_W-N_IRQ_CH){1'b0}}, ier_q};
  assign isr_word_o = {{(DATA_W-N_IRQ_CH){1'b0}}, isr_q};

  p_start_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && core_ready_i && !auto_q && !(wr_ctrl && wr_data_i[B_START]) |=> !start_o);
  p_auto_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && auto_q |=> start_o);
  p_auto_relaunch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_done_i && auto_q |=> start_o);
  p_done_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_done_i |=> ctrl_word_o[B_DONE]);
  p_isr_ready_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ready_i |=> isr_word_o[1]);
  p_irq_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_word_o[0] |-> !irq_o);

endmodule

// File: rtl/acc_arg_bank.sv
module acc_arg_bank
  import acc_ctrl_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic [STRB_W-1:0]              wr_strb_i,
  output logic [N_ARGS-1:0][DATA_W-1:0]  args_o
);

  for (genvar g = 0; g < N_ARGS; g++) begin : g_arg
    logic              hit;
    logic [DATA_W-1:0] word_q;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(ARG_IDX[g]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '0;
      end else if (hit) begin
        for (int b = 0; b < STRB_W; b++) begin
          if (wr_strb_i[b]) word_q[b*8 +: 8] <= wr_data_i[b*8 +: 8];
        end
      end
    end

    assign args_o[g] = word_q;

    p_arg_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(args_o[g]));
  end

endmodule

// File: rtl/acc_capture.sv
module acc_capture #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] data_o,
  output logic             vld_o
);

  logic [WIDTH-1:0] data_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (vld_i) data_q <= data_i;
      vld_q <= (vld_q && !clr_i) || vld_i;
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;

  // shared by status (R10) and result (R11) instances
  p_valid_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  p_hold_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(data_o));

endmodule

// File: rtl/acc_ctrl_regs.sv
module acc_ctrl_regs
  import acc_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W  = ADDR_W - 2,
  localparam int unsigned STRB_W = DATA_W / 8,
  localparam int unsigned RES_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              core_start_o,
  input  logic              core_done_i,
  input  logic              core_idle_i,
  input  logic              core_ready_i,
  output logic [DATA_W-1:0] arg_a_o,
  output logic [DATA_W-1:0] arg_b_o,
  output logic [DATA_W-1:0] instr_o,
  input  logic [DATA_W-1:0] stat_i,
  input  logic              stat_vld_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              res_vld_i,
  output logic              irq_o
);

  logic                          wr_en, rd_en;
  logic [IDX_W-1:0]              wr_idx, rd_idx;
  logic [DATA_W-1:0]             wr_data, rd_word;
  logic [STRB_W-1:0]             wr_strb;
  logic [DATA_W-1:0]             ctrl_word, gie_word, ier_word, isr_word;
  logic [N_ARGS-1:0][DATA_W-1:0] args;
  logic [DATA_W-1:0]             stat_q;
  logic [RES_W-1:0]              res_q;
  logic                          stat_v, res_v, clr_stat_v, clr_res_v;

  acc_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port (
    .clk_i, .rst_ni,
    .awaddr_i, .awvalid_i, .awready_o,
    .wdata_i, .wstrb_i, .wvalid_i, .wready_o,
    .bresp_o, .bvalid_o, .bready_i,
    .araddr_i, .arvalid_i, .arready_o,
    .rdata_o, .rresp_o, .rvalid_o, .rready_i,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .wr_strb_o(wr_strb),
    .rd_en_o(rd_en), .rd_idx_o(rd_idx), .rd_word_i(rd_word)
  );

  acc_run_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_run (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx),
    .core_done_i, .core_idle_i, .core_ready_i,
    .start_o(core_start_o), .irq_o,
    .ctrl_word_o(ctrl_word), .gie_word_o(gie_word),
    .ier_word_o(ier_word), .isr_word_o(isr_word)
  );

  acc_arg_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_args (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .args_o(args)
  );

  assign arg_a_o = args[0];
  assign arg_b_o = args[1];
  assign instr_o = args[2];

  assign clr_stat_v = rd_en && (rd_idx == IDX_W'(W_STAT_V));
  assign clr_res_v  = rd_en && (rd_idx == IDX_W'(W_RES_V));

  acc_capture #(.WIDTH(DATA_W)) i_stat (
    .clk_i, .rst_ni, .vld_i(stat_vld_i), .data_i(stat_i),
    .clr_i(clr_stat_v), .data_o(stat_q), .vld_o(stat_v)
  );

  acc_capture #(.WIDTH(RES_W)) i_res (
    .clk_i, .rst_ni, .vld_i(res_vld_i), .data_i(res_i),
    .clr_i(clr_res_v), .data_o(res_q), .vld_o(res_v)
  );

  always_comb begin
    rd_word = '0;
    if      (rd_idx == IDX_W'(W_CTRL))   rd_word = ctrl_word;
    else if (rd_idx == IDX_W'(W_GIE))    rd_word = gie_word;
    else if (rd_idx == IDX_W'(W_IER))    rd_word = ier_word;
    else if (rd_idx == IDX_W'(W_ISR))    rd_word = isr_word;
    else if (rd_idx == IDX_W'(W_ARG_A))  rd_word = args[0];
    else if (rd_idx == IDX_W'(W_ARG_B))  rd_word = args[1];
    else if (rd_idx == IDX_W'(W_INSTR))  rd_word = args[2];
    else if (rd_idx == IDX_W'(W_STAT))   rd_word = stat_q;
    else if (rd_idx == IDX_W'(W_STAT_V)) rd_word = {{(DATA_W-1){1'b0}}, stat_v};
    else if (rd_idx == IDX_W'(W_RES_LO)) rd_word = res_q[DATA_W-1:0];
    else if (rd_idx == IDX_W'(W_RES_HI)) rd_word = res_q[RES_W-1:DATA_W];
    else if (rd_idx == IDX_W'(W_RES_V))  rd_word = {{(DATA_W-1){1'b0}}, res_v};
  end

  p_read_clears_stat_v_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_stat_v && !stat_vld_i |=> !stat_v);
  p_read_clears_res_v_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_res_v && !res_vld_i |=> !res_v);

endmodule

// File: tb/test_acc_ctrl_regs.sv
module test_acc_ctrl_regs;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] awaddr_i = '0, araddr_i = '0;
  logic              awvalid_i = 1'b0, wvalid_i = 1'b0, arvalid_i = 1'b0;
  logic              bready_i = 1'b1, rready_i = 1'b1;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [3:0]        wstrb_i = '0;
  logic              awready_o, wready_o, bvalid_o, arready_o, rvalid_o;
  logic [1:0]        bresp_o, rresp_o;
  logic [DATA_W-1:0] rdata_o;
  logic              core_start_o, irq_o;
  logic              core_done_i = 1'b0, core_idle_i = 1'b0, core_ready_i = 1'b0;
  logic [DATA_W-1:0] arg_a_o, arg_b_o, instr_o;
  logic [DATA_W-1:0] stat_i = '0;
  logic              stat_vld_i = 1'b0, res_vld_i = 1'b0;
  logic [63:0]       res_i = '0;

  int n_chk = 0;
  int n_err = 0;
  bit coll_done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk_i = ~clk_i;

  acc_ctrl_regs i_acc_ctrl_regs (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each completed read with the queued expectation
  always @(negedge clk_i) begin
    if (rvalid_o && rready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected read response", {32'h0, rdata_o}, 64'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata_o == e && rresp_o == 2'b00, t, {30'h0, rresp_o, rdata_o}, {32'h0, e});
      end
    end
  end

  task automatic wr(input logic [7:0] addr, input logic [31:0] data, input logic [3:0] strb = 4'hF);
    @(negedge clk_i);
    awaddr_i = addr[ADDR_W-1:0]; awvalid_i = 1'b1;
    wdata_i = data; wstrb_i = strb; wvalid_i = 1'b1;
    @(negedge clk_i);
    awvalid_i = 1'b0; wvalid_i = 1'b0;
    if (coll_done) core_done_i = 1'b1;
    @(negedge clk_i);
    core_done_i = 1'b0;
    chk(bvalid_o && bresp_o == 2'b00, "R2 write response", {62'h0, bresp_o}, 64'h0);
    while (bvalid_o) @(negedge clk_i);
  endtask

  task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    araddr_i = addr[ADDR_W-1:0]; arvalid_i = 1'b1;
    if (coll_done) core_done_i = 1'b1;
    @(negedge clk_i);
    arvalid_i = 1'b0;
    core_done_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic pulse(input bit is_ready);
    @(negedge clk_i);
    if (is_ready) core_ready_i = 1'b1; else core_done_i = 1'b1;
    @(negedge clk_i);
    core_ready_i = 1'b0; core_done_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    chk(!core_start_o && !irq_o, "R1 start/irq low", {62'h0, core_start_o, irq_o}, 64'h0);
    chk(!bvalid_o && !rvalid_o, "R1 no responses", {62'h0, bvalid_o, rvalid_o}, 64'h0);
    chk(arg_a_o == 0 && instr_o == 0, "R1 args zero", {arg_a_o, instr_o}, 64'h0);
    rd(8'h00, 32'h0, "R1 ctrl reset");
    rd(8'h0C, 32'h0, "R1 isr reset");

    // arguments with byte strobes
    wr(8'h10, 32'hDEADBEEF);
    wr(8'h18, 32'h12345678);
    wr(8'h34, 32'hA5A5A5A5);
    chk(arg_b_o == 32'h12345678 && instr_o == 32'hA5A5A5A5, "R9 arg outputs",
        {arg_b_o, instr_o}, {32'h12345678, 32'hA5A5A5A5});
    wr(8'h10, 32'h00000011, 4'b0001);
    chk(arg_a_o == 32'hDEADBE11, "R9 byte strobe", {32'h0, arg_a_o}, {32'h0, 32'hDEADBE11});
    rd(8'h10, 32'hDEADBE11, "R9 read arg a");
    rd(8'h34, 32'hA5A5A5A5, "R9 read instr");

    // reserved words
    wr(8'h14, 32'hFFFFFFFF);
    wr(8'h3C, 32'hFFFFFFFF);
    rd(8'h14, 32'h0, "R12 reserved 0x14");
    rd(8'h1C, 32'h0, "R12 reserved 0x1C");
    rd(8'h38, 32'h0, "R12 reserved 0x38");
    rd(8'h3C, 32'h0, "R12 unmapped 0x3C");
    rd(8'h10, 32'hDEADBE11, "R12 neighbour intact");
    rd(8'h18, 32'h12345678, "R12 neighbour intact");

    // enables
    wr(8'h04, 32'hFFFFFFFF);
    wr(8'h08, 32'hFFFFFFFF);
    rd(8'h04, 32'h1, "R6 gie");
    rd(8'h08, 32'h3, "R6 ier");
    chk(!irq_o, "R8 no status no irq", {63'h0, irq_o}, 64'h0);

    // start handshake
    wr(8'h00, 32'h1);
    chk(core_start_o, "R3 start set", {63'h0, core_start_o}, 64'h1);
    wr(8'h00, 32'h0);
    chk(core_start_o, "R3 write 0 no effect", {63'h0, core_start_o}, 64'h1);
    pulse(1'b1);
    chk(!core_start_o, "R3 start cleared by ready", {63'h0, core_start_o}, 64'h0);
    chk(irq_o, "R8 irq on ready status", {63'h0, irq_o}, 64'h1);
    rd(8'h0C, 32'h2, "R7 ready status");
    wr(8'h0C, 32'h2);
    chk(!irq_o, "R8 irq gone after toggle", {63'h0, irq_o}, 64'h0);
    wr(8'h0C, 32'h1);
    chk(irq_o, "R7 toggle 0->1", {63'h0, irq_o}, 64'h1);
    wr(8'h0C, 32'h1);
    rd(8'h0C, 32'h0, "R7 toggled back");

    // done flag and live bits
    pulse(1'b0);
    rd(8'h00, 32'h2, "R5 done sticky");
    rd(8'h00, 32'h0, "R5 done cleared by read");
    core_idle_i = 1'b1;
    rd(8'h00, 32'h4, "R5 idle mirror");
    core_idle_i = 1'b0;

    // collision: done pulse on the clearing read
    pulse(1'b0);
    coll_done = 1'b1;
    rd(8'h00, 32'h2, "R5 collision read old");
    coll_done = 1'b0;
    rd(8'h00, 32'h2, "R5 collision set wins");
    rd(8'h00, 32'h0, "R5 collision then cleared");

    chk(irq_o, "R8 irq done channel", {63'h0, irq_o}, 64'h1);
    wr(8'h04, 32'h0);
    chk(!irq_o, "R8 gie off", {63'h0, irq_o}, 64'h0);
    wr(8'h04, 32'h1);
    wr(8'h08, 32'h2);
    chk(!irq_o, "R8 channel masked", {63'h0, irq_o}, 64'h0);
    wr(8'h08, 32'h3);
    chk(irq_o, "R8 channel unmasked", {63'h0, irq_o}, 64'h1);

    // collision: done pulse on a toggling write
    coll_done = 1'b1;
    wr(8'h0C, 32'h1);
    coll_done = 1'b0;
    rd(8'h0C, 32'h1, "R7 event beats toggle");
    rd(8'h00, 32'h2, "R5 done from collision");
    wr(8'h0C, 32'h1);
    rd(8'h0C, 32'h0, "R7 cleared by toggle");
    chk(!irq_o, "R8 irq low", {63'h0, irq_o}, 64'h0);

    // auto-restart
    wr(8'h00, 32'h81);
    rd(8'h00, 32'h81, "R4 auto and start readback");
    pulse(1'b1);
    chk(core_start_o, "R4 ready keeps start", {63'h0, core_start_o}, 64'h1);
    wr(8'h00, 32'h0);
    pulse(1'b1);
    chk(!core_start_o, "R4 auto off then ready", {63'h0, core_start_o}, 64'h0);
    wr(8'h00, 32'h80);
    chk(!core_start_o, "R4 auto alone no start", {63'h0, core_start_o}, 64'h0);
    pulse(1'b0);
    chk(core_start_o, "R4 done relaunches", {63'h0, core_start_o}, 64'h1);
    wr(8'h00, 32'h0);
    pulse(1'b1);
    chk(!core_start_o, "R3 start cleared", {63'h0, core_start_o}, 64'h0);
    rd(8'h00, 32'h2, "R5 done after auto run");
    rd(8'h0C, 32'h3, "R7 both channels");
    wr(8'h0C, 32'h3);

    // status capture
    @(negedge clk_i);
    stat_i = 32'hCAFEF00D; stat_vld_i = 1'b1;
    @(negedge clk_i);
    stat_vld_i = 1'b0; stat_i = 32'h0;
    rd(8'h20, 32'hCAFEF00D, "R10 status word");
    rd(8'h24, 32'h1, "R10 status valid");
    rd(8'h24, 32'h0, "R10 valid cleared on read");
    rd(8'h20, 32'hCAFEF00D, "R10 word held");

    // result capture
    @(negedge clk_i);
    res_i = 64'h0123456789ABCDEF; res_vld_i = 1'b1;
    @(negedge clk_i);
    res_vld_i = 1'b0; res_i = '0;
    rd(8'h28, 32'h89ABCDEF, "R11 result low");
    rd(8'h2C, 32'h01234567, "R11 result high");
    rd(8'h30, 32'h1, "R11 result valid");
    rd(8'h30, 32'h0, "R11 valid cleared on read");

    // read response held while rready low
    @(negedge clk_i);
    rready_i = 1'b0;
    exp_q.push_back(32'hA5A5A5A5);
    tag_q.push_back("R2 held read data");
    araddr_i = 6'h34; arvalid_i = 1'b1;
    @(negedge clk_i);
    arvalid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(rvalid_o && !arready_o, "R2 rvalid held, arready low", {62'h0, rvalid_o, arready_o}, 64'h2);
    @(posedge clk_i);
    #1 rready_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(!rvalid_o, "R2 rvalid released", {63'h0, rvalid_o}, 64'h0);

    // write response held while bready low
    @(negedge clk_i);
    bready_i = 1'b0;
    awaddr_i = 6'h18; awvalid_i = 1'b1; wdata_i = 32'h55AA55AA; wstrb_i = 4'hF; wvalid_i = 1'b1;
    @(negedge clk_i);
    awvalid_i = 1'b0; wvalid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(bvalid_o && !awready_o && !wready_o, "R2 bvalid held",
        {61'h0, bvalid_o, awready_o, wready_o}, 64'h4);
    chk(arg_b_o == 32'h55AA55AA, "R9 write applied once", {32'h0, arg_b_o}, {32'h0, 32'h55AA55AA});
    @(posedge clk_i);
    #1 bready_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(!bvalid_o, "R2 bvalid released", {63'h0, bvalid_o}, 64'h0);

    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 all reads answered", 64'(exp_q.size()), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog expired", 64'h0, 64'h1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule